// File: doc/BRIEF.md
# Floating-Point Status Flag Unit

This block owns the floating-point status word of a single-precision floating-point unit. Each time the external arithmetic datapath completes an operation, it reports its raw exception indications and its 32-bit result. The unit clears the previous causes and records the new ones. It accumulates sticky flags for exceptions that are masked, keeps a summary bit, and raises a one-cycle exception request carrying a fixed vector number when an enabled cause appears. The rounding mode held in the status word is driven back to the datapath.

The unit also keeps the integer zero, sign and overflow condition flags that floating-point instructions produce. An arithmetic or conversion result sets zero and sign from its bits. A compare operation decodes a 2-bit relation code into the three flags. Software may overwrite the status word at any time. Every register updates on the clock edge that commits the operation or write.

Top module: `fpsu_top`

## Requirements
- R1: After reset, statusWord, roundMode, flagZ, flagS, flagO and excReq are all 0.
- R2: Every committed operation first clears the whole cause field (bits 8:3). It then sets cause bit 3+i for each excFlags[i] that is 1 (i = 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact).
- R3: Sticky flag bit 14+i becomes 1 on an operation with excFlags[i]=1 only when enable bit 9+i is 0. Sticky bits are never cleared by an operation.
- R4: An operation with denormIn or denormOut set sets the unimplemented-processing cause (bit 8), unless the flush-to-zero control bit (bit 2) is 1.
- R5: Bit 31 (summary) equals the OR of the sticky bits 18:14 after every operation and after every software write.
- R6: excReq is high for exactly the one cycle in which the status word shows the committed update, and only when (cause bits 7:3 AND enable bits 13:9) is nonzero or cause bit 8 is set. excVector is 21. The status word is still updated.
- R7: roundMode equals status bits 1:0 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity).
- R8: For a non-compare operation, flagZ is 1 exactly when result bits 30:0 are all zero, flagS equals result bit 31, and flagO keeps its value.
- R9: For a compare (cmpCode 0 equal, 1 less, 2 greater, 3 unordered), flagZ is 1 only for equal, flagS only for less and flagO only for unordered. Exception flags are processed as in R2 to R6.
- R10: A software write loads bits 18:0 from swWrData. Bit 31 of the written value is ignored, and bits 30:19 read as 0.
- R11: An operation with no exception indications leaves the sticky bits unchanged and leaves the cause field zero.
- R12: When swWrEn and opValid are both high, the write commits and the operation is dropped: the condition flags keep their values and no excReq is raised.
- R13: In a cycle with neither opValid nor swWrEn, the status word and condition flags keep their values whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An FP operation completes this cycle |
| opIsCmp | input | 1 | The completing operation is a compare |
| excFlags | input | 5 | Raw exceptions: 0 invalid, 1 div-by-zero, 2 overflow, 3 underflow, 4 inexact |
| denormIn | input | 1 | Denormal operand seen |
| denormOut | input | 1 | Denormal result produced |
| result | input | 32 | Operation result bits |
| cmpCode | input | 2 | Compare relation: 0 equal, 1 less, 2 greater, 3 unordered |
| swWrEn | input | 1 | Software write of the status word |
| swWrData | input | 32 | Value written by software |
| statusWord | output | 32 | Current status word |
| roundMode | output | 2 | Rounding mode to the datapath |
| flagZ | output | 1 | Integer zero flag |
| flagS | output | 1 | Integer sign flag |
| flagO | output | 1 | Integer overflow flag |
| excReq | output | 1 | One-cycle exception request |
| excVector | output | 8 | Exception vector number |

## Verification
The hardest states to reach from the ports are those where cause and sticky diverge. An enabled exception must set its cause and raise a request while its sticky bit stays clear, and a masked exception must do the opposite. Reaching them takes a software write that sets a chosen enable pattern before the operation. A write is also used to set the flush-to-zero bit, so that the same denormal indication shows the unimplemented cause once without it and once suppressed. The bench applies a write and an operation in the same cycle to check that the write takes the status word and the condition flags stay untouched.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_EXC    = 5;
  localparam int CAUSE_W    = NUM_EXC + 1;
  localparam int RM_W       = 2;
  localparam int FTZ_BIT    = 2;
  localparam int CAUSE_LSB  = 3;
  localparam int EN_LSB     = CAUSE_LSB + CAUSE_W;
  localparam int STICKY_LSB = EN_LSB + NUM_EXC;
  localparam int SUM_BIT    = WORD_W - 1;

  localparam logic [WORD_W-1:0] RM_MASK   = WORD_W'((1 << RM_W) - 1);
  localparam logic [WORD_W-1:0] FTZ_MASK  = WORD_W'(1) << FTZ_BIT;
  localparam logic [WORD_W-1:0] EN_MASK   = WORD_W'((1 << NUM_EXC) - 1) << EN_LSB;
  localparam logic [WORD_W-1:0] CTRL_MASK = RM_MASK | FTZ_MASK | EN_MASK;
  localparam logic [WORD_W-1:0] WR_MASK   = WORD_W'((1 << (STICKY_LSB + NUM_EXC)) - 1);
  localparam logic [WORD_W-1:0] SUM_MASK  = WORD_W'(1) << SUM_BIT;

  localparam logic [1:0] CMP_EQ = 2'd0;
  localparam logic [1:0] CMP_LT = 2'd1;
  localparam logic [1:0] CMP_GT = 2'd2;
  localparam logic [1:0] CMP_UN = 2'd3;

  typedef struct packed {
    logic doOp;
    logic doWrite;
    logic isCmp;
  } fpsuStrobe_t;
endpackage

// File: rtl/fpsu_ctrl.sv
module fpsu_ctrl
  import fpsu_pkg::*;
(
  input  logic        opValid,
  input  logic        opIsCmp,
  input  logic        swWrEn,
  output fpsuStrobe_t strb
);
  // A software write in the same cycle takes precedence and drops the operation.
  always_comb begin
    strb.doWrite = swWrEn;
    strb.doOp    = opValid & ~swWrEn;
    strb.isCmp   = opValid & ~swWrEn & opIsCmp;
  end
endmodule

// File: rtl/fpsu_dp.sv
module fpsu_dp
  import fpsu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  fpsuStrobe_t        strb,
  input  logic [NUM_EXC-1:0] excFlags,
  input  logic               denormIn,
  input  logic               denormOut,
  input  logic [WORD_W-1:0]  result,
  input  logic [1:0]         cmpCode,
  input  logic [WORD_W-1:0]  swWrData,
  output logic [WORD_W-1:0]  statusWord,
  output logic               flagZ,
  output logic               flagS,
  output logic               flagO,
  output logic               excReq
);
  logic [WORD_W-1:0]  statusQ;
  logic [NUM_EXC-1:0] enQ, stickyQ, stickyNew;
  logic [CAUSE_W-1:0] causeNew;
  logic               ftzQ, raise;
  logic [WORD_W-1:0]  opWord, wrMasked, wrWord;

  assign enQ     = statusQ[EN_LSB +: NUM_EXC];
  assign stickyQ = statusQ[STICKY_LSB +: NUM_EXC];
  assign ftzQ    = statusQ[FTZ_BIT];

  // Per-exception cause and sticky logic
  for (genvar g = 0; g < NUM_EXC; g++) begin : g_exc
    assign causeNew[g]  = excFlags[g];
    assign stickyNew[g] = stickyQ[g] | (excFlags[g] & ~enQ[g]);
  end
  assign causeNew[NUM_EXC] = (denormIn | denormOut) & ~ftzQ;

  // Unimplemented-processing cause acts as an always-set enable
  assign raise = |(causeNew & {1'b1, enQ});

  always_comb begin
    opWord = (statusQ & CTRL_MASK)
           | (WORD_W'(causeNew)  << CAUSE_LSB)
           | (WORD_W'(stickyNew) << STICKY_LSB)
           | ({WORD_W{|stickyNew}} & SUM_MASK);
    wrMasked = swWrData & WR_MASK;
    wrWord   = (wrMasked & ~SUM_MASK)
             | ({WORD_W{|wrMasked[STICKY_LSB +: NUM_EXC]}} & SUM_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      flagZ   <= 1'b0;
      flagS   <= 1'b0;
      flagO   <= 1'b0;
      excReq  <= 1'b0;
    end else begin
      excReq <= strb.doOp & raise;
      if (strb.doWrite) begin
        statusQ <= wrWord;
      end else if (strb.doOp) begin
        statusQ <= opWord;
        if (strb.isCmp) begin
          flagZ <= (cmpCode == CMP_EQ);
          flagS <= (cmpCode == CMP_LT);
          flagO <= (cmpCode == CMP_UN);
        end else begin
          flagZ <= (result[WORD_W-2:0] == '0);
          flagS <= result[WORD_W-1];
        end
      end
    end
  end

  assign statusWord = statusQ;

  // R6: a request only follows a committed operation
  p_req_after_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(strb.doOp));

  // R6: the unimplemented cause cannot be masked
  p_ce_unmasked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doOp && (denormIn || denormOut) && !ftzQ) |=> excReq);

  // R3: operations never clear sticky bits
  p_sticky_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.doOp |=> (($past(stickyQ) & ~stickyQ) == '0));

  // R5: summary tracks the sticky field
  p_summary_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[SUM_BIT] == (|stickyQ));

  // R13: idle cycles hold the status word
  p_idle_stable_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.doOp && !strb.doWrite) |=> $stable(statusQ));

  // R12: a write drops the operation's request
  p_write_drops_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |=> !excReq);
endmodule

// File: rtl/fpsu_top.sv
module fpsu_top
  import fpsu_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int EXC_VECTOR = 21
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic               opIsCmp,
  input  logic [NUM_EXC-1:0] excFlags,
  input  logic               denormIn,
  input  logic               denormOut,
  input  logic [WORD_W-1:0]  result,
  input  logic [1:0]         cmpCode,
  input  logic               swWrEn,
  input  logic [WORD_W-1:0]  swWrData,
  output logic [WORD_W-1:0]  statusWord,
  output logic [RM_W-1:0]    roundMode,
  output logic               flagZ,
  output logic               flagS,
  output logic               flagO,
  output logic               excReq,
  output logic [VEC_W-1:0]   excVector
);
  fpsuStrobe_t strb;

  fpsu_ctrl u_ctrl (
    .opValid (opValid),
    .opIsCmp (opIsCmp),
    .swWrEn  (swWrEn),
    .strb    (strb)
  );

  fpsu_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .excFlags   (excFlags),
    .denormIn   (denormIn),
    .denormOut  (denormOut),
    .result     (result),
    .cmpCode    (cmpCode),
    .swWrData   (swWrData),
    .statusWord (statusWord),
    .flagZ      (flagZ),
    .flagS      (flagS),
    .flagO      (flagO),
    .excReq     (excReq)
  );

  assign roundMode = statusWord[RM_W-1:0];
  assign excVector = VEC_W'(EXC_VECTOR);
endmodule

// File: tb/sim_fpsu_top.sv
`timescale 1ns/1ps
module sim_fpsu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0, opIsCmp = 1'b0;
  logic [4:0]  excFlags = '0;
  logic        denormIn = 1'b0, denormOut = 1'b0;
  logic [31:0] result = '0;
  logic [1:0]  cmpCode = '0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic [31:0] statusWord;
  logic [1:0]  roundMode;
  logic        flagZ, flagS, flagO, excReq;
  logic [7:0]  excVector;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [31:0] mStat = '0;
  logic mZ = 0, mS = 0, mO = 0;

  always #2.5 clk = ~clk;

  fpsu_top u0 (.clk(clk), .rstN(rstN), .opValid(opValid), .opIsCmp(opIsCmp),
    .excFlags(excFlags), .denormIn(denormIn), .denormOut(denormOut), .result(result),
    .cmpCode(cmpCode), .swWrEn(swWrEn), .swWrData(swWrData), .statusWord(statusWord),
    .roundMode(roundMode), .flagZ(flagZ), .flagS(flagS), .flagO(flagO),
    .excReq(excReq), .excVector(excVector));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag);
    check({tag, " flagZ"}, 32'(flagZ), 32'(mZ));
    check({tag, " flagS"}, 32'(flagS), 32'(mS));
    check({tag, " flagO"}, 32'(flagO), 32'(mO));
  endtask

  function automatic logic [31:0] wrModel(input logic [31:0] d);
    logic [31:0] w = d & 32'h0007_FFFF;
    w[31] = |w[18:14];
    return w;
  endfunction

  task automatic clearIn();
    opValid = 0; opIsCmp = 0; excFlags = '0; denormIn = 0; denormOut = 0;
    swWrEn = 0; swWrData = '0; result = '0; cmpCode = '0;
  endtask

  task automatic swWrite(input logic [31:0] d, input string tag);
    @(negedge clk);
    swWrEn = 1; swWrData = d;
    @(negedge clk);
    mStat = wrModel(d);
    check({tag, " status"}, statusWord, mStat);
    check({tag, " R7 roundMode"}, 32'(roundMode), 32'(mStat[1:0]));
    check({tag, " R5 summary"}, 32'(statusWord[31]), 32'(|mStat[18:14]));
    clearIn();
  endtask

  task automatic runOp(input logic cmp, input logic [4:0] exc, input logic dIn,
                       input logic dOut, input logic [31:0] res, input logic [1:0] cc,
                       input string tag);
    logic [4:0] en, stN;
    logic [5:0] cause;
    logic req;
    en = mStat[13:9];
    cause = {(dIn | dOut) & ~mStat[2], exc};
    stN = mStat[18:14] | (exc & ~en);
    req = |(cause & {1'b1, en});
    @(negedge clk);
    opValid = 1; opIsCmp = cmp; excFlags = exc; denormIn = dIn; denormOut = dOut;
    result = res; cmpCode = cc;
    @(negedge clk);
    mStat = {|stN, 12'b0, stN, en, cause, mStat[2:0]};
    if (cmp) begin
      mZ = (cc == 2'd0); mS = (cc == 2'd1); mO = (cc == 2'd3);
    end else begin
      mZ = (res[30:0] == 0); mS = res[31];
    end
    check({tag, " status"}, statusWord, mStat);
    check({tag, " R6 excReq"}, 32'(excReq), 32'(req));
    if (req) check({tag, " R6 vector"}, 32'(excVector), 32'd21);
    checkFlags(tag);
    clearIn();
    @(negedge clk);
    check({tag, " R6 pulse ends"}, 32'(excReq), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 status", statusWord, 32'd0);
    check("R1 roundMode", 32'(roundMode), 32'd0);
    check("R1 excReq", 32'(excReq), 32'd0);
    checkFlags("R1");
  endtask

  task automatic t_roundModes();
    swWrite(32'hFFF8_0001, "R10 R7 rm1 reserved dropped");
    swWrite(32'h0000_0002, "R7 rm2");
    swWrite(32'h0000_0003, "R7 rm3");
    swWrite(32'h0000_0000, "R7 rm0");
  endtask

  task automatic t_masked();
    runOp(0, 5'b00100, 0, 0, 32'h3F80_0000, 2'd0, "R2 R3 R5 masked overflow");
    runOp(0, 5'b00011, 0, 0, 32'h0000_0000, 2'd0, "R2 R3 invalid divzero zero result R8");
    runOp(0, 5'b00000, 0, 0, 32'h8000_0000, 2'd0, "R11 R8 no exc negative zero");
  endtask

  task automatic t_enabled();
    swWrite(32'h0000_2000, "R10 enable inexact");
    runOp(0, 5'b10000, 0, 0, 32'h4000_0001, 2'd0, "R6 R3 enabled inexact");
    runOp(0, 5'b01000, 0, 0, 32'hC000_0000, 2'd0, "R3 masked underflow no req");
  endtask

  task automatic t_denorm();
    swWrite(32'h0000_0000, "R10 clear");
    runOp(0, 5'b00000, 1, 0, 32'h0000_0001, 2'd0, "R4 R6 denormIn unmaskable");
    runOp(0, 5'b00000, 0, 1, 32'h0000_0001, 2'd0, "R4 denormOut");
    swWrite(32'h0000_0004, "R10 set flush");
    runOp(0, 5'b00000, 1, 1, 32'h0000_0001, 2'd0, "R4 flush suppresses");
  endtask

  task automatic t_compare();
    runOp(1, 5'b00000, 0, 0, 32'h0, 2'd0, "R9 equal");
    runOp(1, 5'b00000, 0, 0, 32'h0, 2'd1, "R9 less");
    runOp(1, 5'b00000, 0, 0, 32'h0, 2'd2, "R9 greater");
    runOp(1, 5'b00001, 0, 0, 32'h0, 2'd3, "R9 unordered invalid");
    runOp(0, 5'b00000, 0, 0, 32'h0000_0010, 2'd0, "R8 flagO kept");
  endtask

  task automatic t_collide();
    @(negedge clk);
    swWrEn = 1; swWrData = 32'h0000_0201;
    opValid = 1; excFlags = 5'b00001; denormIn = 1; result = 32'h8000_0000;
    @(negedge clk);
    mStat = wrModel(32'h0000_0201);
    check("R12 write wins status", statusWord, mStat);
    check("R12 no excReq", 32'(excReq), 32'd0);
    checkFlags("R12");
    clearIn();
  endtask

  task automatic t_idle();
    @(negedge clk);
    excFlags = 5'b11111; denormIn = 1; result = 32'h8000_0000; cmpCode = 2'd1;
    swWrData = 32'hFFFF_FFFF; opIsCmp = 1;
    repeat (3) @(negedge clk);
    check("R13 idle status", statusWord, mStat);
    check("R13 idle excReq", 32'(excReq), 32'd0);
    checkFlags("R13 idle");
    clearIn();
  endtask

  task automatic t_writeSticky();
    swWrite(32'h8004_4000, "R10 R5 bit31 ignored sticky kept");
    swWrite(32'h8000_0000, "R10 R5 bit31 alone");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_roundModes();
    t_masked();
    t_enabled();
    t_denorm();
    t_compare();
    t_collide();
    t_idle();
    t_writeSticky();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule